// File: doc/BRIEF.md
# Data Address Breakpoint Comparator

This block sits in front of the data memory port and inspects each load or store before it proceeds. A low address is first moved into the region of the running process: when the process identifier is nonzero and the access falls in the bottom 32 MiB, the identifier replaces the top address bits. The block then applies an optional word-alignment check to the resulting address. It also runs up to two breakpoint comparisons on that address.

The comparators have two modes. In the plain mode they act as two separate word-address matchers, and each one has its own access-type enable. In the mask mode the second breakpoint word becomes an inverted mask for the first. A match gives a one-cycle breakpoint pulse. If debug is globally enabled, the match also records a data-breakpoint entry code in a debug status word. While that code stays pending, later matches are suppressed until software clears it. All settings are loaded through a simple register write port. What happens after an abort or a breakpoint is left to the surrounding logic.

Top module: `dabc_top`

## Requirements
- R1: After reset, `abort_o` and `bkpt_o` are 0 and `dbg_status_o` is 0. All setting registers are 0, so relocation, alignment checking and both comparators are off.
- R2: `phys_addr_o` is combinational. It equals {PID register bits 31:25, `acc_addr_i`[24:0]} when the PID register (select 0, only bits 31:25 kept) is nonzero and `acc_addr_i`[31:25] is zero.
- R3: In every other case `phys_addr_o` equals `acc_addr_i`.
- R4: When bit 0 of the config register (select 1) is set, a sampled access whose relocated address has bits 1:0 nonzero makes `abort_o` high for exactly the next cycle. When that bit is clear, no abort is raised.
- R5: The breakpoint control register is select 4. Its bits 1:0 enable comparator 0 and bits 3:2 enable comparator 1. Each enable field works as follows: 0 = off, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R6: In plain mode (control bit 8 clear), comparator k hits when the relocated address equals breakpoint word k (select 2 for word 0, select 3 for word 1) with bits 1:0 ignored. Either hit makes `bkpt_o` high for exactly the next cycle.
- R7: In mask mode (control bit 8 set), the hit condition is that the relocated address equals word 0 at every bit where word 1 is 0. Only the enable in bits 1:0 applies, and the enable in bits 3:2 has no effect.
- R8: The debug status register is select 5. Bit 31 is the debug enable and bits 4:2 hold the entry code. A hit while bit 31 is set writes code 3'b010 into bits 4:2. When bit 31 is clear, the pulse still fires but the code is left unchanged.
- R9: When bit 31 is set and bits 4:2 are nonzero, an entry is pending. During that time no breakpoint pulse is produced.
- R10: A register write takes effect in the cycle after it is sampled. A write to the debug status register in the same cycle as a hit takes priority over the recorded code.
- R11: Breakpoint comparison uses the relocated address, not the raw access address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access strobe, sampled at the rising edge |
| acc_addr_i | input | 32 | Access address before relocation |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 PID, 1 config, 2/3 breakpoint words, 4 control, 5 debug status) |
| wr_data_i | input | 32 | Register write data |
| phys_addr_o | output | 32 | Relocated address (combinational) |
| abort_o | output | 1 | Alignment abort pulse |
| bkpt_o | output | 1 | Breakpoint pulse |
| dbg_status_o | output | 32 | Debug status word: bit 31 enable, bits 4:2 entry code |

## Verification
`phys_addr_o` has no register, so the bench checks it one time step after it drives the address, within the same cycle. The abort pulse, the breakpoint pulse and the entry-code update all appear one cycle after the access is sampled. The bench drives each access at a falling edge and reads the result at the following falling edge, then confirms the pulse has dropped one cycle later. Register writes are applied the same way, so every access in the bench sees the settings written before it.

// File: rtl/dabc_pkg.sv
package dabc_pkg;
    localparam int ADDR_W = 32;
    localparam int PID_W  = 7;
    localparam int MOE_W  = 3;
    localparam int SEL_W  = 3;
    localparam int NUM_CMP = 2;

    localparam logic [SEL_W-1:0] SEL_PID  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BP0  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BP1  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DBG  = 3'd5;

    localparam logic [MOE_W-1:0] MOE_DATA_BP = 3'b010;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_STORE = 2'd1,
        EN_ANY   = 2'd2,
        EN_LOAD  = 2'd3
    } cmp_en_e;

    typedef struct packed {
        logic    mask_mode;
        cmp_en_e en1;
        cmp_en_e en0;
    } bp_ctrl_t;
endpackage

// File: rtl/dabc_regs.sv
module dabc_regs
    import dabc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [PID_W-1:0]  pid_o,
    output logic              align_en_o,
    output logic [ADDR_W-1:0] bp0_o,
    output logic [ADDR_W-1:0] bp1_o,
    output bp_ctrl_t          ctrl_o
);
    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic              align_en;
        logic [ADDR_W-1:0] bp0;
        logic [ADDR_W-1:0] bp1;
        bp_ctrl_t          ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_PID:  regs_d.pid      = wr_data_i[ADDR_W-1 -: PID_W];
                SEL_CFG:  regs_d.align_en = wr_data_i[0];
                SEL_BP0:  regs_d.bp0      = wr_data_i;
                SEL_BP1:  regs_d.bp1      = wr_data_i;
                SEL_CTRL: regs_d.ctrl     = '{mask_mode: wr_data_i[8],
                                              en1: cmp_en_e'(wr_data_i[3:2]),
                                              en0: cmp_en_e'(wr_data_i[1:0])};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign pid_o      = regs_q.pid;
    assign align_en_o = regs_q.align_en;
    assign bp0_o      = regs_q.bp0;
    assign bp1_o      = regs_q.bp1;
    assign ctrl_o     = regs_q.ctrl;

    // R10: unselected state holds when no write is presented
    a_r10_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(regs_q));
endmodule

// File: rtl/dabc_xlate.sv
module dabc_xlate
    import dabc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int LOW_W = ADDR_W - PID_W;

    logic relocate;

    always_comb begin
        relocate = (pid_i != '0) && (addr_i[ADDR_W-1 -: PID_W] == '0);
        addr_o   = relocate ? {pid_i, addr_i[LOW_W-1:0]} : addr_i;
    end

    // R2/R3: the offset within the region is never altered
    always_comb begin
        a_r2_low_bits_kept: assert (addr_o[LOW_W-1:0] == addr_i[LOW_W-1:0]);
    end
endmodule

// File: rtl/dabc_match.sv
module dabc_match
    import dabc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              store_i,
    input  logic [ADDR_W-1:0] bp0_i,
    input  logic [ADDR_W-1:0] bp1_i,
    input  bp_ctrl_t          ctrl_i,
    output logic [NUM_CMP-1:0] hit_o
);
    logic [ADDR_W-1:0] bp_word [NUM_CMP];
    cmp_en_e           bp_en   [NUM_CMP];

    assign bp_word[0] = bp0_i;
    assign bp_word[1] = bp1_i;
    assign bp_en[0]   = ctrl_i.en0;
    assign bp_en[1]   = ctrl_i.en1;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        logic type_ok;
        logic addr_eq;
        always_comb begin
            type_ok = (bp_en[k] != EN_OFF) &&
                      (store_i ? (bp_en[k] != EN_LOAD) : (bp_en[k] != EN_STORE));
            if (ctrl_i.mask_mode) begin
                if (k == 0) addr_eq = ((addr_i ^ bp0_i) & ~bp1_i) == '0;
                else        addr_eq = 1'b0;
            end else begin
                addr_eq = addr_i[ADDR_W-1:2] == bp_word[k][ADDR_W-1:2];
            end
            hit_o[k] = type_ok && addr_eq;
        end
    end

    // R5: a disabled comparator never reports a hit
    always_comb begin
        a_r5_off_no_hit: assert (!(ctrl_i.en0 == EN_OFF && hit_o[0]));
    end
endmodule

// File: rtl/dabc_top.sv
module dabc_top
    import dabc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_valid_i,
    input  logic [31:0]       acc_addr_i,
    input  logic              acc_store_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       phys_addr_o,
    output logic              abort_o,
    output logic              bkpt_o,
    output logic [31:0]       dbg_status_o
);
    localparam int MOE_LSB = 2;

    logic [PID_W-1:0]   pid;
    logic               align_en;
    logic [ADDR_W-1:0]  bp0, bp1;
    bp_ctrl_t           ctrl;
    logic [NUM_CMP-1:0] hit;

    typedef struct packed {
        logic             abort;
        logic             bkpt;
        logic             dbg_en;
        logic [MOE_W-1:0] moe;
    } state_t;

    state_t st_d, st_q;
    logic   pending;
    logic   bp_fire;
    logic   dbg_wr;

    dabc_regs u_regs (
        .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
        .pid_o(pid), .align_en_o(align_en), .bp0_o(bp0), .bp1_o(bp1), .ctrl_o(ctrl)
    );

    dabc_xlate u_xlate (.addr_i(acc_addr_i), .pid_i(pid), .addr_o(phys_addr_o));

    dabc_match u_match (
        .addr_i(phys_addr_o), .store_i(acc_store_i),
        .bp0_i(bp0), .bp1_i(bp1), .ctrl_i(ctrl), .hit_o(hit)
    );

    always_comb begin
        st_d     = st_q;
        pending  = st_q.dbg_en && (st_q.moe != '0);
        bp_fire  = acc_valid_i && !pending && (hit != '0);
        dbg_wr   = wr_en_i && (wr_sel_i == SEL_DBG);
        st_d.abort = acc_valid_i && align_en && (phys_addr_o[1:0] != 2'b00);
        st_d.bkpt  = bp_fire;
        if (dbg_wr) begin
            st_d.dbg_en = wr_data_i[31];
            st_d.moe    = wr_data_i[MOE_LSB +: MOE_W];
        end else if (bp_fire && st_q.dbg_en) begin
            st_d.moe = MOE_DATA_BP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign abort_o      = st_q.abort;
    assign bkpt_o       = st_q.bkpt;
    assign dbg_status_o = {st_q.dbg_en, {(31-MOE_LSB-MOE_W){1'b0}}, st_q.moe, {MOE_LSB{1'b0}}};

    a_r4_abort_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> $past(acc_valid_i));
    a_r6_bkpt_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bkpt_o |-> $past(acc_valid_i));
    a_r9_pending_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.dbg_en && st_q.moe != '0) |=> !bkpt_o);
    a_r9_moe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.dbg_en && st_q.moe != '0 && !dbg_wr) |=> $stable(st_q.moe));
endmodule

// File: tb/dabc_top_tb_top.sv
`timescale 1ns/1ps
module dabc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_store = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] phys_addr;
    logic        abort_w, bkpt_w;
    logic [31:0] dbg_status;

    int checks = 0;
    int errors = 0;
    logic got_abort, got_bkpt;

    always #2 clk = ~clk;

    dabc_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
        .acc_store_i(acc_store), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .phys_addr_o(phys_addr), .abort_o(abort_w), .bkpt_o(bkpt_w), .dbg_status_o(dbg_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one access at a falling edge, capture pulses one cycle later
    task automatic access(input logic [31:0] a, input logic st);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_store = st;
        @(negedge clk);
        acc_valid = 1'b0;
        got_abort = abort_w;
        got_bkpt  = bkpt_w;
    endtask

    task automatic t_reset;
        check("R1 abort", {31'b0, abort_w}, 32'h0);
        check("R1 bkpt", {31'b0, bkpt_w}, 32'h0);
        check("R1 status", dbg_status, 32'h0);
        access(32'h0000_1001, 1'b1);
        check("R1 no abort at reset", {31'b0, got_abort}, 32'h0);
        check("R1 no bkpt at reset", {31'b0, got_bkpt}, 32'h0);
    endtask

    task automatic t_reloc;
        @(negedge clk); acc_addr = 32'h0000_1234; #1;
        check("R3 no pid", phys_addr, 32'h0000_1234);
        wr(3'd0, 32'h1400_0000 | 32'h0000_FFFF);
        acc_addr = 32'h0000_1234; #1;
        check("R2 relocated", phys_addr, 32'h1400_1234);
        acc_addr = 32'h01FF_FFFC; #1;
        check("R2 top of low region", phys_addr, 32'h15FF_FFFC);
        acc_addr = 32'h0200_0000; #1;
        check("R3 upper bits set", phys_addr, 32'h0200_0000);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_align;
        access(32'h0000_0002, 1'b0);
        check("R4 disabled", {31'b0, got_abort}, 32'h0);
        wr(3'd1, 32'h1);
        access(32'h0000_0002, 1'b0);
        check("R4 misaligned", {31'b0, got_abort}, 32'h1);
        @(negedge clk);
        check("R4 single cycle", {31'b0, abort_w}, 32'h0);
        access(32'h0000_0008, 1'b1);
        check("R4 aligned", {31'b0, got_abort}, 32'h0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_enables;
        wr(3'd2, 32'h0000_4000);
        wr(3'd4, 32'h1);
        access(32'h0000_4000, 1'b1); check("R5 store-only store", {31'b0, got_bkpt}, 32'h1);
        @(negedge clk); check("R6 single cycle", {31'b0, bkpt_w}, 32'h0);
        access(32'h0000_4000, 1'b0); check("R5 store-only load", {31'b0, got_bkpt}, 32'h0);
        wr(3'd4, 32'h2);
        access(32'h0000_4000, 1'b0); check("R5 any load", {31'b0, got_bkpt}, 32'h1);
        access(32'h0000_4000, 1'b1); check("R5 any store", {31'b0, got_bkpt}, 32'h1);
        wr(3'd4, 32'h3);
        access(32'h0000_4000, 1'b1); check("R5 load-only store", {31'b0, got_bkpt}, 32'h0);
        access(32'h0000_4003, 1'b0); check("R6 low bits ignored", {31'b0, got_bkpt}, 32'h1);
        access(32'h0000_4004, 1'b0); check("R6 next word", {31'b0, got_bkpt}, 32'h0);
        wr(3'd4, 32'h0);
        access(32'h0000_4000, 1'b1); check("R5 off", {31'b0, got_bkpt}, 32'h0);
        wr(3'd3, 32'h0000_8000);
        wr(3'd4, 32'h8);
        access(32'h0000_8001, 1'b0); check("R5 cmp1 any", {31'b0, got_bkpt}, 32'h1);
        access(32'h0000_4000, 1'b0); check("R5 cmp0 off while cmp1 on", {31'b0, got_bkpt}, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_mask;
        wr(3'd2, 32'h0000_4000);
        wr(3'd3, 32'h0000_00FF);
        wr(3'd4, 32'h0000_010E); // mask mode, cmp0 any, cmp1 load-only
        access(32'h0000_40A7, 1'b1); check("R7 masked match", {31'b0, got_bkpt}, 32'h1);
        access(32'h0000_4100, 1'b1); check("R7 unmasked bit differs", {31'b0, got_bkpt}, 32'h0);
        access(32'h0000_00FF, 1'b0); check("R7 cmp1 inactive", {31'b0, got_bkpt}, 32'h0);
        wr(3'd4, 32'h0000_0108);
        access(32'h0000_40A7, 1'b1); check("R7 cmp1 enable ignored", {31'b0, got_bkpt}, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_debug;
        wr(3'd2, 32'h0000_4000);
        wr(3'd4, 32'h2);
        access(32'h0000_4000, 1'b0);
        check("R8 disabled pulse", {31'b0, got_bkpt}, 32'h1);
        check("R8 disabled no code", dbg_status, 32'h0);
        wr(3'd5, 32'h0000_0008);
        access(32'h0000_4000, 1'b0);
        check("R9 not pending without enable", {31'b0, got_bkpt}, 32'h1);
        wr(3'd5, 32'h8000_0000);
        access(32'h0000_4000, 1'b0);
        check("R8 pulse", {31'b0, got_bkpt}, 32'h1);
        check("R8 code recorded", dbg_status, 32'h8000_0008);
        access(32'h0000_4000, 1'b0);
        check("R9 suppressed", {31'b0, got_bkpt}, 32'h0);
        check("R9 code kept", dbg_status, 32'h8000_0008);
        wr(3'd5, 32'h8000_0000);
        // same-cycle write and hit: write wins
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h0000_4000; acc_store = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd5; wr_data = 32'h8000_0000;
        @(negedge clk);
        acc_valid = 1'b0; wr_en = 1'b0;
        check("R10 pulse", {31'b0, bkpt_w}, 32'h1);
        check("R10 write wins", dbg_status, 32'h8000_0000);
        wr(3'd5, 32'h0);
    endtask

    task automatic t_reloc_bp;
        wr(3'd0, 32'h1400_0000);
        wr(3'd2, 32'h1400_2000);
        wr(3'd4, 32'h2);
        access(32'h0000_2000, 1'b1);
        check("R11 relocated hit", {31'b0, got_bkpt}, 32'h1);
        wr(3'd2, 32'h0000_2000);
        access(32'h0000_2000, 1'b1);
        check("R11 raw addr no hit", {31'b0, got_bkpt}, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reloc;
        t_align;
        t_enables;
        t_mask;
        t_debug;
        t_reloc_bp;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule